// File: doc/BRIEF.md
# Three-Phase Half-Bridge Deadtime and Cross-Conduction Guard

This block sits between a PWM generator and three half-bridge gate drivers. For each phase it takes a high-side command and a low-side command and produces a high-side and a low-side gate enable. Before any command reaches the outputs, a glitch filter requires it to hold its new level for a fixed number of clock cycles.

A phase whose two commands are active together has both of its gates turned off. No gate turns on until a programmable deadtime has elapsed with both gates of that phase off. A global mode input selects whether the low-side command is active high or active low. The high-side command is always active high.

The deadtime is given in clock cycles. A select input chooses between a programmed value and the built-in default. The programmed value is clamped to a safe range, 20 to 200 cycles, which is 200 ns to 2 us at 100 MHz. The three phases share the deadtime setting and the mode. Each phase has its own filters, state and deadtime timer.

Top module: `gdg_top`

## Requirements
- R1: When both filtered commands of a phase are active, both gate outputs of that phase go off and stay off until one command is withdrawn. The two outputs of a phase are never on in the same cycle.
- R2: A gate output turns on only after both outputs of its phase have been off for at least the effective deadtime. When a phase switches directly from one side to the other, both outputs are off for exactly the effective deadtime, in cycles.
- R3: With `dt_use_i`=0 the effective deadtime is 20 cycles. With `dt_use_i`=1 it is `dt_set_i` clamped to the range 20..200, so a setting of 5 gives 20 and a setting of 300 gives 200.
- R4: With `lo_inv_i`=0 the low-side command is active when the bit is 1. With `lo_inv_i`=1 it is active when the bit is 0. The high-side command is active at 1 in both modes. A released input (high-side 0, low-side at its inactive level) leaves the outputs off.
- R5: The phases are independent. Activity on one phase never changes the outputs of another phase.
- R6: A command level held for fewer than 7 consecutive clock cycles is discarded and changes no output. A level held for 7 cycles is accepted. With no deadtime pending, the output first shows the change after the 8th rising edge following the input change.
- R7: While `rst_ni` is low, all outputs are off. After reset the deadtime timer counts from zero. A command that is active at release therefore turns its output on only after the effective deadtime has elapsed.
- R8: If a command is withdrawn while its deadtime is still running, the pending turn-on is dropped and that output stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_cmd_i | input | 3 | High-side commands, one bit per phase, active high |
| lo_cmd_i | input | 3 | Low-side commands, one bit per phase, polarity set by `lo_inv_i` |
| lo_inv_i | input | 1 | 1: low-side commands are active low |
| dt_use_i | input | 1 | 1: use `dt_set_i`; 0: use the default deadtime |
| dt_set_i | input | 9 | Programmed deadtime in clock cycles |
| hi_gate_o | output | 3 | High-side gate enables |
| lo_gate_o | output | 3 | Low-side gate enables |

## Verification
The hardest case to reach is a turn-on that has been armed but not yet issued. Reaching it needs the deadtime timer still running, the opposite output already off, and the waiting command then withdrawn. The stimulus sets the deadtime to its 200-cycle maximum and switches a phase from high side to low side. It holds the low-side command for only 40 cycles, well beyond the filter time, and then watches the low output for 300 cycles. Glitch rejection is probed at the filter edge with pulses of 6 and 7 cycles on a phase whose timer has already saturated.

// File: rtl/gdg_pkg.sv
package gdg_pkg;
  localparam int unsigned PHASES_DEF  = 3;
  localparam int unsigned DT_W_DEF    = 9;
  localparam int unsigned DT_MIN_DEF  = 20;
  localparam int unsigned DT_MAX_DEF  = 200;
  localparam int unsigned FILT_LEN_DEF = 7;

  typedef enum logic [1:0] {
    GATE_OFF = 2'b00,
    GATE_HI  = 2'b01,
    GATE_LO  = 2'b10
  } gate_state_e;
endpackage

// File: rtl/gdg_glitch_filter.sv
module gdg_glitch_filter #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned LEN   = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] flt_o
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [CW-1:0] cnt_q;
    logic          lvl_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        lvl_q <= 1'b0;
      end else if (raw_i[g] == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        // new level held LEN sampled edges
        cnt_q <= '0;
        lvl_q <= raw_i[g];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    assign flt_o[g] = lvl_q;
  end
endmodule

// File: rtl/gdg_dt_select.sv
module gdg_dt_select #(
  parameter int unsigned DT_W   = 9,
  parameter int unsigned DT_MIN = 20,
  parameter int unsigned DT_MAX = 200
) (
  input  logic            use_i,
  input  logic [DT_W-1:0] set_i,
  output logic [DT_W-1:0] dt_o
);
  localparam logic [DT_W-1:0] LO = DT_W'(DT_MIN);
  localparam logic [DT_W-1:0] HI = DT_W'(DT_MAX);

  always_comb begin
    if (!use_i)          dt_o = LO;
    else if (set_i < LO) dt_o = LO;
    else if (set_i > HI) dt_o = HI;
    else                 dt_o = set_i;
  end
endmodule

// File: rtl/gdg_phase.sv
module gdg_phase
  import gdg_pkg::*;
#(
  parameter int unsigned DT_W = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hi_req_i,
  input  logic            lo_req_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            hi_o,
  output logic            lo_o
);
  gate_state_e     st_q;
  logic [DT_W-1:0] cnt_q;
  logic            clash;
  logic            dt_done;

  assign clash   = hi_req_i & lo_req_i;
  assign dt_done = (cnt_q >= dt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= GATE_OFF;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        GATE_HI: if (clash || !hi_req_i) begin
          st_q  <= GATE_OFF;
          cnt_q <= DT_W'(1);
        end
        GATE_LO: if (clash || !lo_req_i) begin
          st_q  <= GATE_OFF;
          cnt_q <= DT_W'(1);
        end
        default: begin
          if (!dt_done) cnt_q <= cnt_q + 1'b1;
          else if (hi_req_i && !lo_req_i) st_q <= GATE_HI;
          else if (lo_req_i && !hi_req_i) st_q <= GATE_LO;
        end
      endcase
    end
  end

  assign hi_o = (st_q == GATE_HI);
  assign lo_o = (st_q == GATE_LO);
endmodule

// File: rtl/gdg_top.sv
module gdg_top
  import gdg_pkg::*;
#(
  parameter int unsigned NUM_PH   = PHASES_DEF,
  parameter int unsigned DT_W     = DT_W_DEF,
  parameter int unsigned DT_MIN   = DT_MIN_DEF,
  parameter int unsigned DT_MAX   = DT_MAX_DEF,
  parameter int unsigned FILT_LEN = FILT_LEN_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_PH-1:0] hi_cmd_i,
  input  logic [NUM_PH-1:0] lo_cmd_i,
  input  logic              lo_inv_i,
  input  logic              dt_use_i,
  input  logic [DT_W-1:0]   dt_set_i,
  output logic [NUM_PH-1:0] hi_gate_o,
  output logic [NUM_PH-1:0] lo_gate_o
);
  logic [NUM_PH-1:0] lo_act;
  logic [NUM_PH-1:0] hi_flt;
  logic [NUM_PH-1:0] lo_flt;
  logic [DT_W-1:0]   dt_eff;

  // polarity folded in ahead of the filter so a mode flip is filtered too
  assign lo_act = lo_cmd_i ^ {NUM_PH{lo_inv_i}};

  gdg_dt_select #(.DT_W(DT_W), .DT_MIN(DT_MIN), .DT_MAX(DT_MAX)) u_dt (
    .use_i (dt_use_i),
    .set_i (dt_set_i),
    .dt_o  (dt_eff)
  );

  gdg_glitch_filter #(.WIDTH(NUM_PH), .LEN(FILT_LEN)) u_flt_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (hi_cmd_i),
    .flt_o  (hi_flt)
  );

  gdg_glitch_filter #(.WIDTH(NUM_PH), .LEN(FILT_LEN)) u_flt_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (lo_act),
    .flt_o  (lo_flt)
  );

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    gdg_phase #(.DT_W(DT_W)) u_ph (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hi_req_i (hi_flt[p]),
      .lo_req_i (lo_flt[p]),
      .dt_i     (dt_eff),
      .hi_o     (hi_gate_o[p]),
      .lo_o     (lo_gate_o[p])
    );
  end
endmodule

// File: rtl/gdg_checker.sv
module gdg_checker
  import gdg_pkg::*;
#(
  parameter int unsigned NUM_PH = PHASES_DEF,
  parameter int unsigned DT_W   = DT_W_DEF,
  parameter int unsigned DT_MIN = DT_MIN_DEF,
  parameter int unsigned DT_MAX = DT_MAX_DEF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_PH-1:0] hi_gate_o,
  input logic [NUM_PH-1:0] lo_gate_o,
  input logic [DT_W-1:0]   dt_eff
);
  assert_reset_off_R7: assert property (@(posedge clk_i)
    !rst_ni |-> (hi_gate_o == '0 && lo_gate_o == '0));

  assert_dt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dt_eff >= DT_W'(DT_MIN)) && (dt_eff <= DT_W'(DT_MAX)));

  for (genvar p = 0; p < NUM_PH; p++) begin : g_chk
    logic [DT_W-1:0] off_run;

    // cycles with both gates of the phase off, saturating
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        off_run <= '0;
      else if (hi_gate_o[p] || lo_gate_o[p]) off_run <= '0;
      else if (off_run < DT_W'(DT_MAX))    off_run <= off_run + 1'b1;
    end

    assert_no_overlap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hi_gate_o[p] && lo_gate_o[p]));

    assert_hi_deadtime_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hi_gate_o[p]) |-> (off_run >= dt_eff));

    assert_lo_deadtime_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lo_gate_o[p]) |-> (off_run >= dt_eff));
  end
endmodule

bind gdg_top gdg_checker u_gdg_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hi_gate_o (hi_gate_o),
  .lo_gate_o (lo_gate_o),
  .dt_eff    (dt_eff)
);

// File: tb/gdg_top_test.sv
`timescale 1ns/1ps
module gdg_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] hi, lo;
  logic       inv, use_set;
  logic [8:0] dt_set;
  logic [2:0] hi_o, lo_o;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  gdg_top uut (
    .clk_i(clk), .rst_ni(rst_n), .hi_cmd_i(hi), .lo_cmd_i(lo),
    .lo_inv_i(inv), .dt_use_i(use_set), .dt_set_i(dt_set),
    .hi_gate_o(hi_o), .lo_gate_o(lo_o)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_lo(int p, bit active);
    lo[p] = active ^ inv;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // switch a phase to the other side, count cycles with both gates off
  task automatic gap(int p, bit to_lo, int exp, string tag);
    int n = 0;
    int g = 0;
    @(negedge clk);
    if (to_lo) begin hi[p] = 1'b0; set_lo(p, 1'b1); end
    else       begin set_lo(p, 1'b0); hi[p] = 1'b1; end
    while ((to_lo ? hi_o[p] : lo_o[p]) && g < 50) begin g++; @(negedge clk); end
    while (!(to_lo ? lo_o[p] : hi_o[p]) && n < 1000) begin
      if (hi_o[p] || lo_o[p]) break;
      n++; @(negedge clk);
    end
    chk(n == exp, tag, n, exp);
  endtask

  task automatic t_reset_R7();
    rst_n = 1'b0; hi = '0; lo = '0; inv = 1'b0; use_set = 1'b0; dt_set = '0;
    wait_cyc(3);
    chk(hi_o == 0 && lo_o == 0, "R7 outputs off in reset", {hi_o, lo_o}, 0);
    hi[0] = 1'b1;
    wait_cyc(2);
    chk(hi_o == 0, "R7 held off with command active", hi_o, 0);
    rst_n = 1'b1;
    begin
      int n = 0;
      @(negedge clk);
      while (!hi_o[0] && n < 500) begin n++; @(negedge clk); end
      chk(n == 20, "R7 first turn-on waits deadtime", n, 20);
    end
  endtask

  task automatic t_deadtime_R2_R3();
    gap(0, 1'b1, 20, "R2 R3 default deadtime hi->lo");
    @(negedge clk); use_set = 1'b1; dt_set = 9'd50;
    gap(0, 1'b0, 50, "R3 programmed 50 lo->hi");
    @(negedge clk); dt_set = 9'd5;
    gap(0, 1'b1, 20, "R3 clamp low 5->20");
    @(negedge clk); dt_set = 9'd300;
    gap(0, 1'b0, 200, "R3 clamp high 300->200");
    @(negedge clk); use_set = 1'b0;
  endtask

  task automatic t_filter_R6();
    int n = 0;
    bit seen = 0;
    bit stay = 1;
    @(negedge clk); hi[1] = 1'b1;
    @(negedge clk);
    n = 1;
    while (!hi_o[1] && n < 100) begin n++; @(negedge clk); end
    chk(n == 8, "R6 latency edges to output", n, 8);
    @(negedge clk); hi[1] = 1'b0;
    wait_cyc(6); hi[1] = 1'b1;
    repeat (30) begin @(negedge clk); if (!hi_o[1]) stay = 0; end
    chk(stay, "R6 6-cycle low glitch ignored", stay, 1);
    stay = 1;
    hi[2] = 1'b1; wait_cyc(6); hi[2] = 1'b0;
    repeat (30) begin @(negedge clk); if (hi_o[2] || lo_o[2]) stay = 0; end
    chk(stay, "R6 6-cycle high glitch ignored", stay, 1);
    hi[2] = 1'b1; wait_cyc(7); hi[2] = 1'b0;
    repeat (20) begin @(negedge clk); if (hi_o[2]) seen = 1; end
    chk(seen, "R6 7-cycle pulse accepted", seen, 1);
  endtask

  task automatic t_independent_R5();
    wait_cyc(10);
    gap(0, 1'b1, 20, "R5 phase 0 switch with phase 1 on");
    chk(hi_o[1] && !lo_o[1], "R5 phase 1 unchanged", {hi_o[1], lo_o[1]}, 2);
    chk(!hi_o[2] && !lo_o[2], "R5 phase 2 unchanged", {hi_o[2], lo_o[2]}, 0);
  endtask

  task automatic t_clash_R1();
    @(negedge clk); hi[0] = 1'b1;
    wait_cyc(12);
    chk(!hi_o[0] && !lo_o[0], "R1 both commands -> both off", {hi_o[0], lo_o[0]}, 0);
    wait_cyc(40);
    chk(!hi_o[0] && !lo_o[0], "R1 stays off while both active", {hi_o[0], lo_o[0]}, 0);
    set_lo(0, 1'b0);
    wait_cyc(40);
    chk(hi_o[0] && !lo_o[0], "R1 high side resumes after release", {hi_o[0], lo_o[0]}, 2);
  endtask

  task automatic t_invert_R4();
    @(negedge clk); inv = 1'b1; lo = 3'b111;
    wait_cyc(20);
    chk(hi_o[0] && lo_o == 0, "R4 mode flip with idle low inputs", {hi_o, lo_o}, 6'b001000);
    gap(0, 1'b1, 20, "R4 inverted low command drives low gate");
    chk(lo_o[0] && !hi_o[0], "R4 low gate on when lo_cmd=0", lo_o[0], 1);
    @(negedge clk); set_lo(0, 1'b0);
    wait_cyc(12);
    chk(!lo_o[0] && !hi_o[0], "R4 released inputs leave phase off", {hi_o[0], lo_o[0]}, 0);
  endtask

  task automatic t_cancel_R8();
    bit quiet = 1;
    @(negedge clk); use_set = 1'b1; dt_set = 9'd200; hi[0] = 1'b1;
    wait_cyc(250);
    chk(hi_o[0], "R8 setup high side on", hi_o[0], 1);
    @(negedge clk); hi[0] = 1'b0; set_lo(0, 1'b1);
    repeat (40) begin @(negedge clk); if (lo_o[0]) quiet = 0; end
    set_lo(0, 1'b0);
    repeat (300) begin @(negedge clk); if (lo_o[0] || hi_o[0]) quiet = 0; end
    chk(quiet, "R8 withdrawn command never turns on", quiet, 1);
  endtask

  initial begin
    t_reset_R7();
    t_deadtime_R2_R3();
    t_filter_R6();
    t_independent_R5();
    t_clash_R1();
    t_invert_R4();
    t_cancel_R8();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule